// File: doc/BRIEF.md
# I2C Block-Transfer Control Register Slave

This block is a serial-bus slave that holds a small bank of control registers, such as per-output clock enables and frequency-select bits. Its register contents are offered on a flat parallel bus to the rest of the chip. At reset every register loads a fixed default value, so the chip runs correctly even if no bus master ever talks to it.

SCL and SDA are oversampled by a faster system clock. Both lines pass through synchronizer chains before edge and START/STOP detection. A write transfer carries three kinds of byte in turn:

- the device address with the write bit;
- a command byte and a count byte, both acknowledged and then dropped;
- data bytes, stored in order from register 0 onward.

A register cannot be addressed on its own. To change a later register, the master resends every register in front of it.

A read transfer streams the registers from register 0 onward until the master declines a byte or ends the transfer. SDA is open-drain and is modelled as an input plus a pull-low enable.

Top module: `clkctl_i2c_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START seen at any point, including in the middle of a transfer, abandons that transfer and begins address reception again.
- R2: The device address is 7'h69, so a write begins with byte 0xD2 and a read with byte 0xD3 (read/write flag in bit 0). A matching address is acknowledged by pulling SDA low for the ninth clock. A non-matching address is not acknowledged, and the bus is then ignored until the next START: no further acknowledges and no register change.
- R3: In a write, the second byte (command) and the third byte (count) are acknowledged whatever their value, and neither changes any register.
- R4: Every byte on the bus is 8 bits, most significant bit first. In a write, the data bytes after the count byte land in register 0, 1, 2 and onward in arrival order, and each one is acknowledged. Register k is presented on `regs_o[8k+7:8k]`.
- R5: In a write, data bytes beyond the last register (register 7 with 8 registers) are acknowledged but discarded.
- R6: After reset the register bus equals the default vector 64'h00FF_FF7F_3C0F_FF02 (register 0 = 0x02 in the low byte), and SDA is released.
- R7: In a read, the slave returns register 0, then register 1 and onward, most significant bit first, for as long as the master acknowledges. Bytes requested past the last register read as 0xFF.
- R8: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing more until the next START.
- R9: A STOP releases SDA and ends the transfer. The next write starts again at register 0, and registers not reached by a short write keep their values.
- R10: The slave changes its SDA pull only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_pull_o | output | 1 | 1 pulls the open-drain data line low |
| regs_o | output | 64 | Register bank contents, register k at bits 8k+7..8k |

## Verification
The main stimulus is a seeded random sequence of write-then-read transfers. Each one carries a random command byte, a random count byte and between zero and ten data bytes, and is followed by a read of random length. This separates the three cases of the data pointer: writes shorter than the bank, which must leave later registers untouched; writes that exactly fill the bank; and writes that overrun it, which must be discarded. It also separates reads that stop before the end of the bank from reads that run past it and must return 0xFF. Directed cases complete the picture:

- a foreign address, which tells an ignored transfer apart from an acknowledged one;
- a repeated START in the middle of a write, which shows whether the pointer restarts at register 0;
- a master NACK followed by further clocks, which shows whether the slave really lets go of the line.

// File: rtl/clkctl_i2c_pkg.sv
package clkctl_i2c_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_RX     = 3'd1,
    PH_RX_ACK = 3'd2,
    PH_TX     = 3'd3,
    PH_TX_ACK = 3'd4
  } phase_t;

  localparam logic [7:0] FILL_BYTE = 8'hFF;

  // Position of a received byte inside a write transfer.
  localparam logic [1:0] SLOT_ADDR  = 2'd0;
  localparam logic [1:0] SLOT_DATA  = 2'd3;

  function automatic logic addr_match(input logic [7:0] rx, input logic [6:0] dev);
    return rx[7:1] == dev;
  endfunction

  function automatic logic [1:0] next_slot(input logic [1:0] slot);
    return (slot == SLOT_DATA) ? slot : slot + 2'd1;
  endfunction

endpackage

// File: rtl/clkctl_line_sync.sv
module clkctl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // Data edges qualified by SCL high on both sampled cycles (R1).
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/clkctl_reg_bank.sv
module clkctl_reg_bank #(
  parameter int                    NUM_REGS = 8,
  parameter int                    PTR_W    = 4,
  parameter logic [NUM_REGS*8-1:0] DEFAULTS = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [PTR_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [PTR_W-1:0]      rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_o
);
  import clkctl_i2c_pkg::*;

  logic [7:0] bank [NUM_REGS];

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bank[g] <= DEFAULTS[g*8 +: 8];
        end else if (wr_en && (wr_idx == PTR_W'(g))) begin
          bank[g] <= wr_data;
        end
      end
      assign regs_o[g*8 +: 8] = bank[g];
    end
  endgenerate

  // Out-of-range reads return the fill pattern (R7).
  always_comb begin
    rd_data = FILL_BYTE;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == PTR_W'(i)) rd_data = bank[i];
    end
  end

endmodule

// File: rtl/clkctl_xfer_fsm.sv
module clkctl_xfer_fsm #(
  parameter int         NUM_REGS = 8,
  parameter int         PTR_W    = 4,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sda_s,
  input  logic                  scl_rise,
  input  logic                  scl_fall,
  input  logic                  start_evt,
  input  logic                  stop_evt,
  input  logic [7:0]            rd_data,
  output logic                  sda_pull,
  output logic                  wr_en,
  output logic [PTR_W-1:0]      wr_ptr,
  output logic [7:0]            wr_data,
  output logic [PTR_W-1:0]      rd_ptr,
  output logic                  byte_done,
  output logic                  addr_phase,
  output logic                  addr_hit,
  output logic                  master_nack,
  output clkctl_i2c_pkg::phase_t phase_o
);
  import clkctl_i2c_pkg::*;

  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);

  phase_t           phase;
  logic [7:0]       shreg;
  logic [3:0]       bitcnt;
  logic [1:0]       slot;
  logic             read_mode;
  logic [PTR_W-1:0] wptr;
  logic [PTR_W-1:0] rptr;
  logic             mack;
  logic             ack_now;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == PTR_END) ? p : p + PTR_W'(1);
  endfunction

  assign byte_done   = (phase == PH_RX) && scl_fall && (bitcnt == 4'd8);
  assign addr_phase  = (slot == SLOT_ADDR);
  assign addr_hit    = addr_match(shreg, DEV_ADDR);
  assign ack_now     = addr_phase ? addr_hit : 1'b1;
  assign wr_en       = byte_done && (slot == SLOT_DATA) && (wptr < PTR_END);
  assign wr_ptr      = wptr;
  assign wr_data     = shreg;
  assign rd_ptr      = rptr;
  assign master_nack = (phase == PH_TX_ACK) && scl_fall && !mack;
  assign phase_o     = phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      shreg     <= '0;
      bitcnt    <= '0;
      slot      <= SLOT_ADDR;
      read_mode <= 1'b0;
      wptr      <= '0;
      rptr      <= '0;
      sda_pull  <= 1'b0;
      mack      <= 1'b0;
    end else if (start_evt) begin
      phase     <= PH_RX;
      bitcnt    <= '0;
      slot      <= SLOT_ADDR;
      read_mode <= 1'b0;
      wptr      <= '0;
      rptr      <= '0;
      sda_pull  <= 1'b0;
    end else if (stop_evt) begin
      phase    <= PH_IDLE;
      sda_pull <= 1'b0;
    end else begin
      case (phase)
        PH_RX: begin
          if (scl_rise && (bitcnt != 4'd8)) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end
          if (byte_done) begin
            if (ack_now) begin
              sda_pull <= 1'b1;
              phase    <= PH_RX_ACK;
              if (addr_phase) read_mode <= shreg[0];
              if (slot == SLOT_DATA) wptr <= ptr_step(wptr);
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
        PH_RX_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (read_mode) begin
              phase    <= PH_TX;
              shreg    <= rd_data;
              sda_pull <= ~rd_data[7];
            end else begin
              phase    <= PH_RX;
              sda_pull <= 1'b0;
              slot     <= next_slot(slot);
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_pull <= 1'b0;
              phase    <= PH_TX_ACK;
              rptr     <= ptr_step(rptr);
            end else begin
              shreg    <= {shreg[6:0], 1'b0};
              sda_pull <= ~shreg[6];
              bitcnt   <= bitcnt + 4'd1;
            end
          end
        end
        PH_TX_ACK: begin
          if (scl_rise) mack <= ~sda_s;
          if (scl_fall) begin
            if (mack) begin
              phase    <= PH_TX;
              shreg    <= rd_data;
              sda_pull <= ~rd_data[7];
              bitcnt   <= '0;
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
        default: begin
          phase <= PH_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/clkctl_i2c_slave.sv
module clkctl_i2c_slave #(
  parameter int                    NUM_REGS    = 8,
  parameter int                    SYNC_STAGES = 2,
  parameter logic [6:0]            DEV_ADDR    = 7'h69,
  parameter logic [NUM_REGS*8-1:0] DEFAULTS    = 64'h00FF_FF7F_3C0F_FF02
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  import clkctl_i2c_pkg::*;

  localparam int PTR_W = $clog2(NUM_REGS + 1);

  logic             scl_s;
  logic             sda_s;
  logic             scl_rise;
  logic             scl_fall;
  logic             start_evt;
  logic             stop_evt;
  logic             wr_en;
  logic [PTR_W-1:0] wr_ptr;
  logic [7:0]       wr_data;
  logic [PTR_W-1:0] rd_ptr;
  logic [7:0]       rd_data;
  logic             byte_done;
  logic             addr_phase;
  logic             addr_hit;
  logic             master_nack;
  phase_t           phase;

  clkctl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  clkctl_xfer_fsm #(
    .NUM_REGS (NUM_REGS),
    .PTR_W    (PTR_W),
    .DEV_ADDR (DEV_ADDR)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sda_s       (sda_s),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_evt   (start_evt),
    .stop_evt    (stop_evt),
    .rd_data     (rd_data),
    .sda_pull    (sda_pull_o),
    .wr_en       (wr_en),
    .wr_ptr      (wr_ptr),
    .wr_data     (wr_data),
    .rd_ptr      (rd_ptr),
    .byte_done   (byte_done),
    .addr_phase  (addr_phase),
    .addr_hit    (addr_hit),
    .master_nack (master_nack),
    .phase_o     (phase)
  );

  clkctl_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .PTR_W    (PTR_W),
    .DEFAULTS (DEFAULTS)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_ptr),
    .wr_data (wr_data),
    .rd_idx  (rd_ptr),
    .rd_data (rd_data),
    .regs_o  (regs_o)
  );

endmodule

// File: rtl/clkctl_i2c_checker.sv
module clkctl_i2c_checker #(
  parameter int REG_BITS = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   scl_s,
  input logic                   start_evt,
  input logic                   stop_evt,
  input logic                   byte_done,
  input logic                   addr_phase,
  input logic                   addr_hit,
  input logic                   wr_en,
  input logic                   master_nack,
  input clkctl_i2c_pkg::phase_t phase,
  input logic                   sda_pull_o,
  input logic [REG_BITS-1:0]    regs_o
);
  import clkctl_i2c_pkg::*;

  assert_start_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (phase == PH_RX));

  assert_foreign_addr_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && addr_phase && !addr_hit) |=> (!sda_pull_o && phase == PH_IDLE));

  assert_regs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_o));

  assert_write_acked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_pull_o);

  assert_nack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    master_nack |=> (!sda_pull_o && phase == PH_IDLE));

  assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!sda_pull_o && phase == PH_IDLE));

  assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !$past(scl_s));

endmodule

bind clkctl_i2c_slave clkctl_i2c_checker #(.REG_BITS(NUM_REGS*8)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_s       (scl_s),
  .start_evt   (start_evt),
  .stop_evt    (stop_evt),
  .byte_done   (byte_done),
  .addr_phase  (addr_phase),
  .addr_hit    (addr_hit),
  .wr_en       (wr_en),
  .master_nack (master_nack),
  .phase       (phase),
  .sda_pull_o  (sda_pull_o),
  .regs_o      (regs_o)
);

// File: tb/test_clkctl_i2c_slave.sv
module test_clkctl_i2c_slave;
  localparam int          NREG = 8;
  localparam logic [63:0] DEF  = 64'h00FF_FF7F_3C0F_FF02;
  localparam int          Q    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic [63:0] regs;
  wire  sda_line = sda_m & ~sda_pull;

  always #2 clk = ~clk;

  clkctl_i2c_slave i_clkctl_i2c_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull),
    .regs_o     (regs)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int r10_bad = 0;
  bit done = 1'b0;
  bit pull_seen = 1'b0;
  logic prev_pull = 1'b0;
  logic [7:0] model [NREG];

  // Pull changes while SCL is high are counted (R10).
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && (sda_pull !== prev_pull) && scl_m) r10_bad <= r10_bad + 1;
    prev_pull <= sda_pull;
    if (sda_pull) pull_seen <= 1'b1;
    if (cyc == 190000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<190000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input int idx);
    return (idx < NREG) ? model[idx] : 8'hFF;
  endfunction

  function automatic logic [63:0] model_pack();
    logic [63:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    sda_m = 1'b0; wq(2*Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(2*Q);
      scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    ack = !sda_line; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wq(Q);
      scl_m = 1'b1; wq(Q);
      b = {b[6:0], sda_line}; wq(Q);
      scl_m = 1'b0; wq(Q);
    end
    sda_m = !give_ack; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    scl_m = 1'b0; wq(Q);
    sda_m = 1'b1;
  endtask

  task automatic write_hdr(input logic [7:0] cmd, input logic [7:0] cnt);
    bit a;
    bus_start();
    send_byte(8'hD2, a); chk(a, "R2 write address ack", a, 1);
    send_byte(cmd, a);   chk(a, "R3 command ack", a, 1);
    send_byte(cnt, a);   chk(a, "R3 count ack", a, 1);
  endtask

  task automatic write_data(input int k, input logic [7:0] d);
    bit a;
    send_byte(d, a);
    if (k < NREG) begin
      model[k] = d;
      chk(a, "R4 data ack", a, 1);
    end else begin
      chk(a, "R5 overflow byte ack", a, 1);
    end
  endtask

  task automatic read_check(input int m);
    bit a;
    logic [7:0] got;
    bus_start();
    send_byte(8'hD3, a); chk(a, "R2 read address ack", a, 1);
    for (int k = 0; k < m; k++) begin
      recv_byte(k < m - 1, got);
      chk(got == model_read(k), (k < NREG) ? "R7 read data" : "R7 read past end", got, model_read(k));
    end
    bus_stop();
  endtask

  initial begin
    bit a;
    int seed_init;
    logic [7:0] got;
    seed_init = $urandom(32'h5EED);
    for (int i = 0; i < NREG; i++) model[i] = DEF[i*8 +: 8];
    wq(5);
    rst_n = 1'b1;
    wq(5);

    // R6 reset state
    chk(regs == DEF, "R6 reset defaults", regs, DEF);
    chk(sda_pull == 1'b0, "R6 line released", sda_pull, 0);

    // R3 header only, registers untouched
    write_hdr(8'h00, 8'h08);
    bus_stop();
    chk(regs == model_pack(), "R3 header-only write", regs, model_pack());

    // R2 foreign address: no ack, rest ignored
    bus_start();
    send_byte(8'hA4, a); chk(!a, "R2 foreign address nack", a, 0);
    send_byte(8'h00, a); chk(!a, "R2 ignored after foreign address", a, 0);
    send_byte(8'h55, a); chk(!a, "R2 ignored data", a, 0);
    bus_stop();
    chk(regs == model_pack(), "R2 foreign transfer left registers", regs, model_pack());

    // R1 / R9: repeated start mid-write restarts at register 0
    write_hdr(8'h00, 8'h02);
    write_data(0, 8'h11);
    write_data(1, 8'h22);
    write_hdr(8'h00, 8'h01);
    write_data(0, 8'h33);
    bus_stop();
    chk(regs[7:0] == 8'h33, "R1 repeated start rewrote register 0", regs[7:0], 8'h33);
    chk(regs[15:8] == 8'h22, "R9 register 1 kept", regs[15:8], 8'h22);
    chk(regs == model_pack(), "R9 short write bank", regs, model_pack());

    // R4 / R5: full bank plus overflow, MSB-first patterns
    write_hdr(8'hFF, 8'h0A);
    for (int k = 0; k < 10; k++) write_data(k, 8'h80 >> (k % 8) ^ 8'(k * 8'h13));
    bus_stop();
    chk(regs == model_pack(), "R5 overflow discarded", regs, model_pack());

    // R7 read past the end
    read_check(10);

    // R8 master NACK then extra clocks: slave stays released
    bus_start();
    send_byte(8'hD3, a); chk(a, "R2 read address ack", a, 1);
    recv_byte(1'b0, got);
    chk(got == model_read(0), "R8 byte before nack", got, model_read(0));
    pull_seen = 1'b0;
    wq(2);
    pull_seen = 1'b0;
    recv_byte(1'b0, got);
    chk(got == 8'hFF, "R8 line released after nack", got, 8'hFF);
    chk(!pull_seen, "R8 no drive after nack", pull_seen, 0);
    bus_stop();

    // Random write/read rounds
    for (int it = 0; it < 12; it++) begin
      int n;
      int m;
      n = $urandom_range(0, 10);
      m = $urandom_range(1, 10);
      write_hdr(8'($urandom), 8'($urandom));
      for (int k = 0; k < n; k++) write_data(k, 8'($urandom));
      bus_stop();
      chk(regs == model_pack(), "R4 bank after random write", regs, model_pack());
      read_check(m);
    end

    wq(10);
    chk(r10_bad == 0, "R10 pull changed with SCL high", r10_bad, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule